// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache between a processor port that can stall and a lower-level memory that moves whole blocks. Each line holds four 32-bit words, with a valid flag, a dirty flag and a stored tag. There are 256 lines, so 1K words in all. Every processor address splits into a tag, a line index, a word-in-block select and a byte offset. The cache answers a hit in the same cycle. When it misses, it holds the processor stalled until the access can complete.

A miss that finds a dirty victim first writes the whole victim block back to memory. After that it requests the new block. The block is installed clean, and the pending access then completes as an ordinary hit. A store that misses therefore always gets the complete block before its bytes are merged, so a line never carries a new tag over words from another block. Stores carry byte enables. Only the enabled bytes of the addressed word change.

The processor keeps `cpu_req` and all its request fields steady until a cycle in which `cpu_stall` is low. At the following clock edge the access is complete. The memory port keeps `mem_req` and its fields steady until a one-cycle `mem_ack`.

Top module: `dmc_cache`

## Requirements
- R1: Address bits [1:0] are the byte offset, [3:2] select the word within the block, [11:4] are the 8-bit line index and [31:12] are the 20-bit tag. Addresses with equal index and different tag compete for one line, while different indices coexist.
- R2: Reset clears every valid flag, so the first access to any line after reset misses and requests memory.
- R3: A hit needs the indexed line to be valid and its stored tag to equal the address tag in all 20 bits. Any mismatch, including one in the most significant address bit, is a miss.
- R4: On a read miss, `cpu_stall` is high and one memory read (`mem_we`=0) of the block-aligned address fetches all four words. The requested word is then returned with `cpu_stall` low.
- R5: A store that hits changes only the cached copy and marks the line dirty. It starts no memory transaction.
- R6: Replacing a dirty line writes its four current words to memory (`mem_we`=1) at the victim's block address. Replacing a clean line issues no write.
- R7: When a victim is dirty, its write-back is acknowledged before the read request for the new block is issued.
- R8: A store that misses fetches the whole new block and merges the store into it. The other three words of the line are those of the fetched block.
- R9: `cpu_be` bit k enables byte k (bits 8k+7:8k) of a store. Bytes whose enable is 0 keep their previous value, and an enable of 0000 changes nothing.
- R10: `mem_addr` always has bits [3:0] equal to zero. While `mem_req` is high without `mem_ack`, the request, its address and its direction stay unchanged.
- R11: A hit completes in the cycle of the request, with `cpu_hit` high and `cpu_stall` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while hit |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Request pending, hold inputs |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | 32 | Block-aligned address |
| mem_wdata | output | 128 | Victim block, word 0 in low bits |
| mem_rdata | input | 128 | Refill block, word 0 in low bits |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench aims at the line shared by two tags. It checks that a dirty victim appears on the memory port with its latest merged data, and that this happens strictly before the refill read. A design that refilled first, or that dropped the write-back, would lose stores, and the later reload would expose this. Store misses are swept over all sixteen byte-enable patterns. A design that wrote the word under the new tag without fetching would return stale neighbour words, and one that ignored enables would clobber bytes. Tags that differ only in the top address bit, and lines at both ends of the index range, catch truncated tag compares and wrong index slicing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int DMC_WORD_W = 32;
    localparam int DMC_BYTES  = DMC_WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } dmc_state_e;

    function automatic logic [DMC_WORD_W-1:0] byte_merge(
        input logic [DMC_WORD_W-1:0] old_w,
        input logic [DMC_WORD_W-1:0] new_w,
        input logic [DMC_BYTES-1:0]  be
    );
        logic [DMC_WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < DMC_BYTES; b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             install,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             set_dirty,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) tag_q[idx] <= new_tag;
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    // a store hit leaves its line dirty
    p_dirty_mark_r5: assert property (@(posedge clk) disable iff (rst)
        set_dirty |=> dirty_q[$past(idx)]);

    // a freshly installed line is valid and clean
    p_install_clean_r8: assert property (@(posedge clk) disable iff (rst)
        install |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES      = 256,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = dmc_pkg::DMC_WORD_W,
    localparam int IDX_W     = $clog2(LINES),
    localparam int WOFF_W    = $clog2(LINE_WORDS),
    localparam int LINE_W    = WORD_W * LINE_WORDS,
    localparam int BYTES     = WORD_W / 8
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFF_W-1:0] word,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_word,
    output logic [LINE_W-1:0] rd_line
);
    logic [LINE_WORDS-1:0][WORD_W-1:0] lines_q [LINES];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            lines_q[idx] <= fill_line;
        end else if (wr_en) begin
            for (int b = 0; b < BYTES; b++)
                if (wr_be[b]) lines_q[idx][word][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
    end

    assign rd_line = lines_q[idx];
    assign rd_word = lines_q[idx][word];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       lookup_hit,
    input  logic       victim_valid,
    input  logic       victim_dirty,
    input  logic       mem_ack,
    output dmc_state_e state,
    output logic       mem_req,
    output logic       mem_we,
    output logic       install,
    output logic       use_victim_addr
);
    dmc_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (cpu_req && !lookup_hit)
                              state_q <= (victim_valid && victim_dirty) ? ST_WBACK : ST_FILL;
                ST_WBACK: if (mem_ack) state_q <= ST_FILL;
                ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state           = state_q;
        mem_req         = (state_q != ST_IDLE);
        mem_we          = (state_q == ST_WBACK);
        use_victim_addr = (state_q == ST_WBACK);
        install         = (state_q == ST_FILL) && mem_ack;
    end

    // acknowledged write-back is followed by the refill read
    p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // an unacknowledged request keeps its direction
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 256,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = DMC_WORD_W,
    localparam int BYTES     = WORD_W / 8,
    localparam int BOFF_W    = $clog2(BYTES),
    localparam int WOFF_W    = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(LINES),
    localparam int LOW_W     = BOFF_W + WOFF_W,
    localparam int TAG_W     = ADDR_W - IDX_W - LOW_W,
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTES-1:0]  cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WOFF_W-1:0] a_word;
    logic              addr_unused;

    assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx       = cpu_addr[LOW_W +: IDX_W];
    assign a_word      = cpu_addr[BOFF_W +: WOFF_W];
    assign addr_unused = ^cpu_addr[BOFF_W-1:0];

    logic             rd_valid, rd_dirty;
    logic [TAG_W-1:0] rd_tag;
    logic             lookup_hit, install, use_victim_addr, wr_en;
    dmc_state_e       state;

    assign lookup_hit = rd_valid && (rd_tag == a_tag);
    assign cpu_hit    = cpu_req && lookup_hit && (state == ST_IDLE);
    assign cpu_stall  = cpu_req && !cpu_hit;
    assign wr_en      = cpu_hit && cpu_we;

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .idx       (a_idx),
        .install   (install),
        .new_tag   (a_tag),
        .set_dirty (wr_en),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_tag    (rd_tag)
    );

    dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
        .clk       (clk),
        .idx       (a_idx),
        .word      (a_word),
        .fill_en   (install),
        .fill_line (mem_rdata),
        .wr_en     (wr_en),
        .wr_be     (cpu_be),
        .wr_data   (cpu_wdata),
        .rd_word   (cpu_rdata),
        .rd_line   (mem_wdata)
    );

    dmc_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cpu_req         (cpu_req),
        .lookup_hit      (lookup_hit),
        .victim_valid    (rd_valid),
        .victim_dirty    (rd_dirty),
        .mem_ack         (mem_ack),
        .state           (state),
        .mem_req         (mem_req),
        .mem_we          (mem_we),
        .install         (install),
        .use_victim_addr (use_victim_addr)
    );

    assign mem_addr = {(use_victim_addr ? rd_tag : a_tag), a_idx, {LOW_W{1'b0}}};

    // nothing can hit in the cycle right after reset
    p_cold_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_hit);

    // memory address stays put until acknowledged
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // no memory traffic while a hit completes
    p_hit_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> !mem_req);

endmodule

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]   cpu_be = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_hit, cpu_stall;
    logic         mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;

    always #5 clk = ~clk;

    dmc_cache u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference contents: latest value per word address
    logic [31:0] ref_mem [logic [29:0]];
    logic [31:0] mem_st  [logic [29:0]];

    function automatic logic [31:0] init_val(input logic [29:0] wa);
        return ({wa, 2'b11} * 32'h0101_0101) ^ 32'hC3A5_0F1E;
    endfunction
    function automatic logic [31:0] exp_word(input logic [29:0] wa);
        return ref_mem.exists(wa) ? ref_mem[wa] : init_val(wa);
    endfunction
    function automatic logic [31:0] mem_word(input logic [29:0] wa);
        return mem_st.exists(wa) ? mem_st[wa] : init_val(wa);
    endfunction

    // memory transaction log for the current access
    int          log_n = 0;
    logic        lg_we   [8];
    logic [31:0] lg_addr [8];
    logic [127:0] lg_data [8];

    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                logic [31:0] a0;
                logic        w0;
                a0 = mem_addr; w0 = mem_we;
                chk(a0[3:0] == 4'h0, "R10", "block alignment", a0, {a0[31:4], 4'h0});
                for (int i = 0; i < LAT; i++) begin
                    @(negedge clk);
                    chk(mem_req && mem_addr == a0 && mem_we == w0, "R10", "request held",
                        mem_addr, a0);
                end
                if (log_n < 8) begin
                    lg_we[log_n] = w0; lg_addr[log_n] = a0; lg_data[log_n] = mem_wdata;
                end
                log_n++;
                if (w0) begin
                    for (int w = 0; w < 4; w++) mem_st[a0[31:2] + 30'(w)] = mem_wdata[w*32 +: 32];
                end else begin
                    for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem_word(a0[31:2] + 30'(w));
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        log_n = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            if (!cpu_stall) break;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        if (we) begin
            logic [31:0] v;
            v = exp_word(a[31:2]);
            for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = wd[b*8 +: 8];
            ref_mem[a[31:2]] = v;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic check_wb(input int k, input logic [31:0] blk, input string req);
        chk(lg_we[k] == 1'b1, req, "write-back direction", 32'(lg_we[k]), 32'd1);
        chk(lg_addr[k] == blk, req, "write-back address", lg_addr[k], blk);
        for (int w = 0; w < 4; w++)
            chk(lg_data[k][w*32 +: 32] == exp_word(blk[31:2] + 30'(w)), req, "write-back word",
                lg_data[k][w*32 +: 32], exp_word(blk[31:2] + 30'(w)));
    endtask

    initial begin
        int cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R2: idle outputs after reset
        chk(!cpu_stall && !cpu_hit && !mem_req, "R2", "idle after reset",
            {29'd0, cpu_stall, cpu_hit, mem_req}, 32'd0);

        // R2 R4: cold read miss fetches whole block
        access(1'b0, 32'h0000_0104, 4'hF, 32'h0, rd, cyc);
        chk(cyc > 0, "R2", "cold access stalls", 32'(cyc), 32'd1);
        chk(log_n == 1 && !lg_we[0] && lg_addr[0] == 32'h0000_0100, "R4", "single block read",
            lg_addr[0], 32'h0000_0100);
        chk(rd == exp_word(30'h41), "R4", "requested word", rd, exp_word(30'h41));

        // R11 R1: other words of the block hit with no stall
        for (int w = 0; w < 4; w++) begin
            access(1'b0, 32'h0000_0100 + 32'(w*4), 4'hF, 32'h0, rd, cyc);
            chk(cyc == 0 && log_n == 0, "R11", "same-block hit", 32'(cyc), 32'd0);
            chk(rd == exp_word(30'h40 + 30'(w)), "R1", "word select", rd, exp_word(30'h40 + 30'(w)));
        end

        // R5: store hit, no memory traffic
        access(1'b1, 32'h0000_0108, 4'hF, 32'hDEAD_BEEF, rd, cyc);
        chk(cyc == 0 && log_n == 0, "R5", "store hit quiet", 32'(log_n), 32'd0);
        // R9: partial store
        access(1'b1, 32'h0000_010F, 4'b0101, 32'h1122_3344, rd, cyc);
        access(1'b0, 32'h0000_010C, 4'hF, 32'h0, rd, cyc);
        chk(rd == exp_word(30'h43), "R9", "byte merge", rd, exp_word(30'h43));

        // R6 R7 R1: conflicting tag evicts dirty line, write-back first
        access(1'b0, 32'h0000_1104, 4'hF, 32'h0, rd, cyc);
        chk(log_n == 2, "R7", "two transfers", 32'(log_n), 32'd2);
        check_wb(0, 32'h0000_0100, "R6");
        chk(!lg_we[1] && lg_addr[1] == 32'h0000_1100, "R7", "refill after write-back",
            lg_addr[1], 32'h0000_1100);
        chk(rd == exp_word(30'h441), "R1", "conflict line data", rd, exp_word(30'h441));

        // R6 R3: clean victim, no write; stored data survives via memory
        access(1'b0, 32'h0000_0108, 4'hF, 32'h0, rd, cyc);
        chk(log_n == 1 && !lg_we[0], "R6", "clean victim no write", 32'(log_n), 32'd1);
        chk(rd == 32'hDEAD_BEEF, "R3", "reloaded store", rd, 32'hDEAD_BEEF);

        // R3: tag differs only in MSB
        access(1'b0, 32'h8000_0104, 4'hF, 32'h0, rd, cyc);
        chk(cyc > 0, "R3", "MSB tag mismatch misses", 32'(cyc), 32'd1);
        chk(rd == exp_word(30'h2000_0041), "R3", "MSB tag data", rd, exp_word(30'h2000_0041));

        // R1: first and last line coexist
        access(1'b0, 32'h0000_0000, 4'hF, 32'h0, rd, cyc);
        access(1'b0, 32'h0000_0FF0, 4'hF, 32'h0, rd, cyc);
        access(1'b0, 32'h0000_0004, 4'hF, 32'h0, rd, cyc);
        chk(cyc == 0, "R1", "index 0 kept", 32'(cyc), 32'd0);
        access(1'b0, 32'h0000_0FFC, 4'hF, 32'h0, rd, cyc);
        chk(cyc == 0 && rd == exp_word(30'h3FF), "R1", "index 255 kept", rd, exp_word(30'h3FF));

        // R8 R9: store miss over every byte-enable pattern
        for (int be = 0; be < 16; be++) begin
            logic [31:0] a;
            a = 32'h0000_3008 + 32'(be * 16);
            access(1'b1, a, 4'(be), 32'hF0E1_D2C3 ^ 32'(be), rd, cyc);
            chk(log_n == 1 && !lg_we[0] && lg_addr[0] == {a[31:4], 4'h0}, "R8", "store miss fetch",
                lg_addr[0], {a[31:4], 4'h0});
            for (int w = 0; w < 4; w++) begin
                logic [31:0] wa;
                wa = {a[31:4], 4'h0} + 32'(w*4);
                access(1'b0, wa, 4'hF, 32'h0, rd, cyc);
                chk(rd == exp_word(wa[31:2]), (w == 2) ? "R9" : "R8", "merged line", rd,
                    exp_word(wa[31:2]));
            end
        end

        // R6 R7: evict those dirty lines with another tag
        for (int be = 0; be < 16; be++) begin
            logic [31:0] a;
            a = 32'h0000_4000 + 32'(be * 16);
            access(1'b0, a, 4'hF, 32'h0, rd, cyc);
            chk(log_n == 2 && !lg_we[1] && lg_addr[1] == a, "R7", "write-back then refill",
                32'(log_n), 32'd2);
            check_wb(0, 32'h0000_3000 + 32'(be * 16), "R6");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule